// File: doc/BRIEF.md
# Two-Wire Bus Hold Watchdog

This block guards a two-wire serial slave against a transaction that never closes. A protocol decoder elsewhere reports each detected START and STOP condition as a single-cycle pulse. A slow reference timebase supplies one pulse per rising edge of its 1 Hz clock. When a START has been seen and no STOP follows in time, the block pulses a reset to the bus interface. It also raises a release signal, so the pad logic lets SDA float to high impedance. This frees a bus that the slave could otherwise hold low.

Timing is counted in whole reference edges, not system clock cycles. The first reference edge after a START only begins the count. The timeout then expires `TIMEOUT_TICKS` edges later. Because a START can land anywhere within a reference period, the real window lies between `TIMEOUT_TICKS` and `TIMEOUT_TICKS + 1` reference periods. With the default value this is between one and two seconds. A STOP at any point before expiry cancels the watch. The block then waits for the next START.

Top module: `bus_hold_watchdog`

## Requirements
- R1: A START pulse seen while idle arms the monitor. A reference tick in the same cycle as that START is not counted. Counting begins at the first reference tick sampled after the arming cycle.
- R2: A STOP pulse while armed or counting returns the monitor to idle and no reset pulse is produced. If a STOP and the expiring tick are sampled in the same cycle, the STOP wins.
- R3: A START pulse while armed or counting is ignored and does not restart the count. Expiry still falls on the same tick it would have without that START.
- R4: Expiry occurs on the tick that is `TIMEOUT_TICKS` ticks after the tick that began counting. Counted from the START, that is tick number `TIMEOUT_TICKS + 1`. `bus_rst_o` is high for exactly the one cycle after that tick is sampled.
- R5: `sda_release_o` rises in the same cycle as `bus_rst_o`. It stays high until a START is sampled and falls in the cycle after that START.
- R6: After an expiry the monitor is idle. Further reference ticks without a new START produce no reset pulse.
- R7: While `rst_ni` is low at a clock edge, the monitor goes idle and both outputs are low from the following cycle. The reset is synchronous and active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle pulse: START condition detected |
| stop_i | input | 1 | One-cycle pulse: STOP condition detected |
| tick_i | input | 1 | One-cycle pulse: rising edge of the 1 Hz reference |
| bus_rst_o | output | 1 | One-cycle reset pulse to the bus interface on timeout |
| sda_release_o | output | 1 | Forces the SDA driver to high impedance after a timeout |

## Verification
The bench sweeps the number of reference ticks between a START and a STOP, from none to beyond expiry. A design that counted the arming tick or began counting at the START would fire one tick early. A counter that was off by one would fire on the wrong tick of the sweep. Targeted sequences cover several coincidences: a tick in the same cycle as the START, a STOP together with the expiring tick, and a second START in mid-count. A design that got these wrong would fire early, fire despite the STOP, or postpone expiry. The bench also checks that extra ticks after expiry stay silent and that the release signal clears only on a new START. A design that re-armed by itself, or tied the release to the pulse, would fail those checks.

// File: rtl/bto_pkg.sv
// Package: shared state encoding for the bus hold watchdog.
// Assumes: nothing beyond a synthesizable enum.
package bto_pkg;

    typedef enum logic [1:0] {
        WD_IDLE     = 2'd0,
        WD_ARMED    = 2'd1,
        WD_COUNTING = 2'd2
    } wd_state_e;

endpackage

// File: rtl/bto_tick_counter.sv
// Module: counts reference ticks while the monitor is counting and flags
// the tick that completes the timeout window.
// Assumes: tick_i is a single-cycle pulse; run_i is low outside counting.
module bto_tick_counter #(
    parameter int TIMEOUT_TICKS = 1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic tick_i,
    output logic expire_o
);
    localparam int CW = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_TICKS - 1);

    logic [CW-1:0] cnt_q;

    // Purpose: advance on each counted tick, clear whenever not counting.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !run_i) begin
            cnt_q <= '0;
        end else if (tick_i && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Purpose: flag the tick that ends the window.
    always_comb begin
        expire_o = run_i && tick_i && (cnt_q == LAST);
    end
endmodule

// File: rtl/bto_fsm.sv
// Module: idle / armed / counting sequencer for the bus hold watchdog.
// Assumes: start_i, stop_i and tick_i are single-cycle pulses on clk_i.
// A STOP takes priority over an expiring tick in the same cycle.
module bto_fsm
    import bto_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      start_i,
    input  logic      stop_i,
    input  logic      tick_i,
    input  logic      expire_i,
    output wd_state_e state_o,
    output logic      fire_o
);
    wd_state_e state_q, state_d;

    // Purpose: compute the next state and the timeout strobe.
    always_comb begin
        state_d = state_q;
        fire_o  = 1'b0;
        unique case (state_q)
            WD_IDLE: begin
                if (start_i) state_d = WD_ARMED;
            end
            WD_ARMED: begin
                if (stop_i)      state_d = WD_IDLE;
                else if (tick_i) state_d = WD_COUNTING;
            end
            WD_COUNTING: begin
                if (stop_i) begin
                    state_d = WD_IDLE;
                end else if (expire_i) begin
                    state_d = WD_IDLE;
                    fire_o  = 1'b1;
                end
            end
            default: state_d = WD_IDLE;
        endcase
    end

    // Purpose: hold the state register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= WD_IDLE;
        else         state_q <= state_d;
    end

    assign state_o = state_q;
endmodule

// File: rtl/bto_out_stage.sv
// Module: registers the interface reset pulse and holds the SDA release
// from a timeout until the next START.
// Assumes: fire_i is a single-cycle strobe.
module bto_out_stage (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fire_i,
    input  logic start_i,
    output logic bus_rst_o,
    output logic sda_release_o
);
    // Purpose: one-cycle reset pulse to the bus interface.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) bus_rst_o <= 1'b0;
        else         bus_rst_o <= fire_i;
    end

    // Purpose: set release on timeout, clear it on the next START.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)      sda_release_o <= 1'b0;
        else if (fire_i)  sda_release_o <= 1'b1;
        else if (start_i) sda_release_o <= 1'b0;
    end
endmodule

// File: rtl/bus_hold_watchdog.sv
// Module: top of the two-wire bus hold watchdog. Arms on START, starts
// counting at the next reference tick, and resets the bus interface if
// no STOP arrives within TIMEOUT_TICKS further ticks.
// Assumes: all pulse inputs are synchronous to clk_i and one cycle wide.
module bus_hold_watchdog
    import bto_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic stop_i,
    input  logic tick_i,
    output logic bus_rst_o,
    output logic sda_release_o
);
    wd_state_e state;
    logic      expire;
    logic      fire;
    logic      run;

    assign run = (state == WD_COUNTING);

    bto_tick_counter #(
        .TIMEOUT_TICKS(TIMEOUT_TICKS)
    ) u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (run),
        .tick_i  (tick_i),
        .expire_o(expire)
    );

    bto_fsm u_fsm (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start_i),
        .stop_i  (stop_i),
        .tick_i  (tick_i),
        .expire_i(expire),
        .state_o (state),
        .fire_o  (fire)
    );

    bto_out_stage u_out (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .fire_i       (fire),
        .start_i      (start_i),
        .bus_rst_o    (bus_rst_o),
        .sda_release_o(sda_release_o)
    );
endmodule

// File: rtl/bus_hold_watchdog_chk.sv
// Module: assertion checker for bus_hold_watchdog, attached with bind.
// Assumes: state_i is the sequencer state of the bound instance.
module bus_hold_watchdog_chk
    import bto_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      start_i,
    input  logic      stop_i,
    input  logic      bus_rst_o,
    input  logic      sda_release_o,
    input  wd_state_e state_i
);
    a_r1_idle_start_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == WD_IDLE && start_i) |=> (state_i == WD_ARMED));

    a_r2_stop_blocks_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_i |=> !bus_rst_o);

    a_r2_stop_returns_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stop_i && state_i != WD_IDLE) |=> (state_i == WD_IDLE));

    a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_rst_o |=> !bus_rst_o);

    a_r4_from_counting: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(bus_rst_o) |-> $past(state_i == WD_COUNTING));

    a_r5_release_with_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_rst_o |-> sda_release_o);

    a_r5_start_clears_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sda_release_o && start_i) |=> !sda_release_o);

    a_r6_idle_after_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_rst_o |-> (state_i != WD_COUNTING));
endmodule

bind bus_hold_watchdog bus_hold_watchdog_chk u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .bus_rst_o    (bus_rst_o),
    .sda_release_o(sda_release_o),
    .state_i      (state)
);

// File: tb/test_bus_hold_watchdog.sv
module test_bus_hold_watchdog;
    localparam int TO = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_r = 1'b0, stop_r = 1'b0, tick_r = 1'b0;
    logic bus_rst, sda_rel;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    bus_hold_watchdog #(.TIMEOUT_TICKS(TO)) i_bus_hold_watchdog (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .start_i      (start_r),
        .stop_i       (stop_r),
        .tick_i       (tick_r),
        .bus_rst_o    (bus_rst),
        .sda_release_o(sda_rel)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // One clock cycle of stimulus; returns at the next negedge, when the
    // outputs already reflect the inputs sampled at the edge in between.
    task automatic cyc(input logic s, input logic p, input logic t);
        start_r = s; stop_r = p; tick_r = t;
        @(negedge clk);
        start_r = 1'b0; stop_r = 1'b0; tick_r = 1'b0;
    endtask

    task automatic idle_gap();
        for (int g = 0; g < 3; g++) begin
            cyc(0, 0, 0);
            chk("R6 gap", bus_rst, 1'b0);
        end
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        chk("R7 reset bus_rst", bus_rst, 1'b0);
        chk("R7 reset release", sda_rel, 1'b0);
        rst_n = 1'b1;

        // Sweep: n ticks after START, then STOP (R1, R2, R4, R5, R6).
        for (int n = 0; n <= TO + 3; n++) begin
            cyc(1, 0, 0);
            chk("R5 start clears release", sda_rel, 1'b0);
            idle_gap();
            for (int k = 1; k <= n; k++) begin
                cyc(0, 0, 1);
                chk((k == TO + 1) ? "R4 expiry tick" : "R1 R6 no early or late fire",
                    bus_rst, (k == TO + 1));
                if (k == TO + 1) begin
                    cyc(0, 0, 0);
                    chk("R4 pulse width", bus_rst, 1'b0);
                end
                idle_gap();
            end
            cyc(0, 1, 0);
            chk("R2 stop no reset", bus_rst, 1'b0);
            chk("R5 release level", sda_rel, (n >= TO + 1));
            idle_gap();
        end

        // Tick in the START cycle is not counted (R1).
        cyc(1, 0, 1);
        chk("R1 start tick", bus_rst, 1'b0);
        for (int k = 1; k <= TO + 1; k++) begin
            cyc(0, 0, 1);
            chk("R1 start tick not counted", bus_rst, (k == TO + 1));
            cyc(0, 0, 0);
        end

        // Repeated START mid-count does not restart (R3).
        cyc(1, 0, 0);
        chk("R5 release cleared", sda_rel, 1'b0);
        cyc(0, 0, 1);
        cyc(1, 0, 0);
        chk("R3 restart ignored", bus_rst, 1'b0);
        for (int k = 2; k <= TO + 1; k++) begin
            cyc(0, 0, 1);
            chk("R3 expiry unchanged", bus_rst, (k == TO + 1));
            cyc(1, 0, 0);
        end
        // the START just given arrived while idle: re-armed; close with STOP
        cyc(0, 1, 0);
        chk("R5 release after start", sda_rel, 1'b0);

        // STOP coincident with the expiring tick wins (R2).
        cyc(1, 0, 0);
        for (int k = 1; k <= TO; k++) cyc(0, 0, 1);
        cyc(0, 1, 1);
        chk("R2 stop beats tick", bus_rst, 1'b0);
        cyc(0, 0, 1);
        chk("R2 idle after stop", bus_rst, 1'b0);
        chk("R2 no release", sda_rel, 1'b0);

        // STOP while armed, before any tick (R2).
        cyc(1, 0, 0);
        cyc(0, 1, 0);
        for (int k = 0; k < TO + 2; k++) begin
            cyc(0, 0, 1);
            chk("R2 armed stop", bus_rst, 1'b0);
        end

        // Reset in mid-count clears everything (R7).
        cyc(1, 0, 0);
        cyc(0, 0, 1);
        rst_n = 1'b0;
        cyc(0, 0, 1);
        rst_n = 1'b1;
        for (int k = 0; k < TO + 2; k++) begin
            cyc(0, 0, 1);
            chk("R7 reset clears count", bus_rst, 1'b0);
        end

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule